// File: doc/BRIEF.md
# Bus Master Burst and Wait-State Controller

This block runs the data phases of a burst issued by a PCI-style bus master. A start pulse opens a transaction. From then on, each cycle it decides whether to drive initiator-ready and whether the current phase is the last one. It bases that decision on three things:

- a flag from the local FIFO that says whether the next data phase can be completed;
- a reloadable burst-length counter;
- a software terminate request.

A phase completes when initiator-ready and target-ready are both high at a rising clock edge.

Two configuration bits set the policy. The counter-enable bit limits the burst length. The no-wait bit chooses how the controller handles a next phase that is not guaranteed. With the bit clear, it stalls with wait states. With the bit set, it ends the burst early. Both bits apply only while the bus-mode input selects PCI mode. Writes to each bit are accepted only in a window guarded by the host-active and master-request flags.

Top module: `bm_burst_ctrl`

## Requirements
- R1: A write (cfg_we_i=1) updates cnt_en_o at the next edge only when master_req_i=1 or host_act_i=0. Otherwise cnt_en_o keeps its value.
- R2: A write updates nowait_o at the next edge only when host_act_i=0. Otherwise nowait_o keeps its value.
- R3: An active-low rst_ni clears cnt_en_o and nowait_o. So does sw_rst_i=1 at a clock edge, and sw_rst_i takes priority over a write in the same cycle.
- R4: With counter-enable set in PCI mode, start_i loads burst_len_i. The burst then ends after exactly that many completed phases, and a value of 0 gives one phase. The counter counts down only on completed phases.
- R5: With counter-enable clear, the burst has no length limit. It runs for at least 70 completed phases.
- R6: term_req_i=1 during a transaction makes every following phase final until a phase completes, and that phase ends the burst. The request is dropped at the end of the burst, and term_req_i is ignored while idle.
- R7: No-wait clear, next_ok_i=0 and no reason to end: irdy_o=0 (wait state).
- R8: No-wait set in PCI mode with next_ok_i=0: irdy_o=1 and last_o=1, so the burst ends on this phase.
- R9: During a transaction with next_ok_i=1, irdy_o=1.
- R10: last_o only rises together with irdy_o. Once high, it stays high until trdy_i completes the phase. busy_o falls the cycle after that completion.
- R11: When bus_mode_i is not 2'b01 (PCI), both configuration bits have no effect. Bursts are unlimited and wait states are always inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_rst_i | input | 1 | Software reset, clears the configuration bits |
| bus_mode_i | input | 2 | Bus mode; 2'b01 is PCI mode |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_cnt_en_i | input | 1 | Write data for counter-enable |
| cfg_nowait_i | input | 1 | Write data for no-wait |
| burst_len_i | input | 6 | Burst length loaded at start |
| master_req_i | input | 1 | Master-request flag |
| host_act_i | input | 1 | Host-active flag |
| start_i | input | 1 | Begin a transaction (taken while idle) |
| term_req_i | input | 1 | Software terminate request |
| next_ok_i | input | 1 | The next data phase can complete |
| trdy_i | input | 1 | Target ready |
| irdy_o | output | 1 | Initiator ready |
| last_o | output | 1 | Final data phase / frame end |
| busy_o | output | 1 | Transaction in progress |
| cnt_en_o | output | 1 | Counter-enable configuration bit |
| nowait_o | output | 1 | No-wait configuration bit |

## Verification
The bench goes after the following corner cases:

- **Burst length 0 and 63.** A counter that wraps would give 64 phases or never end.
- **An unlimited burst.** An off-by-one on disable would end it.
- **Target-ready held low on the final phase.** A design that does not latch the final decision would drop last_o when next_ok_i rises.
- **Terminate requests while idle.** A design that kept a stale request would cut the next burst to one phase.
- **Configuration writes just outside the guard windows, and software reset alongside a write.**
- **Non-PCI modes with both bits set.** A design that ignored the mode would stop inserting wait states.

// File: rtl/bmb_pkg.sv
package bmb_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_DATA = 1'b1} bm_state_e;
endpackage

// File: rtl/bmb_cfg_regs.sv
module bmb_cfg_regs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_rst_i,
  input  logic we_i,
  input  logic cnt_en_d_i,
  input  logic nowait_d_i,
  input  logic master_req_i,
  input  logic host_act_i,
  output logic cnt_en_o,
  output logic nowait_o
);
  logic ce_ok, nw_ok;
  assign ce_ok = we_i && (master_req_i || !host_act_i);
  assign nw_ok = we_i && !host_act_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_en_o <= 1'b0;
      nowait_o <= 1'b0;
    end else if (sw_rst_i) begin
      cnt_en_o <= 1'b0;
      nowait_o <= 1'b0;
    end else begin
      if (ce_ok) cnt_en_o <= cnt_en_d_i;
      if (nw_ok) nowait_o <= nowait_d_i;
    end
  end

  // R1
  ce_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_act_i && !master_req_i && !sw_rst_i) |=> $stable(cnt_en_o));
  // R2
  nw_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_act_i && !sw_rst_i) |=> $stable(nowait_o));
  // R3
  sw_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> (!cnt_en_o && !nowait_o));
endmodule

// File: rtl/bmb_burst_cnt.sv
module bmb_burst_cnt #(
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  input  logic          dec_i,
  output logic          at_term_o
);
  localparam logic [CW-1:0] ONE = CW'(1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= ONE;
    else if (load_i) cnt_q <= (len_i == '0) ? ONE : len_i;  // zero means one phase
    else if (dec_i)  cnt_q <= cnt_q - ONE;
  end

  assign at_term_o = (cnt_q == ONE);

  // R4
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> (cnt_q > ONE));
  // R4
  cnt_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != '0);
endmodule

// File: rtl/bm_burst_ctrl.sv
module bm_burst_ctrl
  import bmb_pkg::*;
#(
  parameter int             CW       = 6,
  parameter int             MW       = 2,
  parameter logic [MW-1:0]  PCI_MODE = MW'(1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sw_rst_i,
  input  logic [MW-1:0] bus_mode_i,
  input  logic          cfg_we_i,
  input  logic          cfg_cnt_en_i,
  input  logic          cfg_nowait_i,
  input  logic [CW-1:0] burst_len_i,
  input  logic          master_req_i,
  input  logic          host_act_i,
  input  logic          start_i,
  input  logic          term_req_i,
  input  logic          next_ok_i,
  input  logic          trdy_i,
  output logic          irdy_o,
  output logic          last_o,
  output logic          busy_o,
  output logic          cnt_en_o,
  output logic          nowait_o
);
  bm_state_e state_q;
  logic term_pend_q, ending_q;
  logic pci, eff_cnt, eff_nw, in_data, at_term, fin, done, load, dec;

  bmb_cfg_regs u_cfg (
    .clk_i, .rst_ni, .sw_rst_i,
    .we_i(cfg_we_i), .cnt_en_d_i(cfg_cnt_en_i), .nowait_d_i(cfg_nowait_i),
    .master_req_i, .host_act_i,
    .cnt_en_o, .nowait_o
  );

  bmb_burst_cnt #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni, .load_i(load), .len_i(burst_len_i), .dec_i(dec),
    .at_term_o(at_term)
  );

  assign pci     = (bus_mode_i == PCI_MODE);
  assign eff_cnt = cnt_en_o && pci;
  assign eff_nw  = nowait_o && pci;
  assign in_data = (state_q == ST_DATA);

  // final phase: sticky end, sw terminate, count expiry, or no-wait early end
  assign fin  = in_data && (ending_q || term_pend_q || (eff_cnt && at_term) ||
                            (eff_nw && !next_ok_i));
  assign irdy_o = in_data && (next_ok_i || fin);
  assign last_o = fin;
  assign busy_o = in_data;
  assign done   = irdy_o && trdy_i;
  assign load   = !in_data && start_i;
  assign dec    = done && !fin && eff_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      term_pend_q <= 1'b0;
      ending_q    <= 1'b0;
    end else if (!in_data) begin
      term_pend_q <= 1'b0;
      ending_q    <= 1'b0;
      if (start_i) state_q <= ST_DATA;
    end else if (done && fin) begin
      state_q     <= ST_IDLE;
      term_pend_q <= 1'b0;
      ending_q    <= 1'b0;
    end else begin
      if (term_req_i) term_pend_q <= 1'b1;
      if (fin)        ending_q    <= 1'b1;
    end
  end

  // R10
  last_irdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> irdy_o);
  // R10
  last_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !trdy_i) |=> last_o);
  // R10
  end_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && trdy_i) |=> !busy_o);
  // R7
  wait_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last_o && !next_ok_i) |-> !irdy_o);
  // R8
  no_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && nowait_o && pci && !next_ok_i) |-> (irdy_o && last_o));
  // R9
  ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && next_ok_i) |-> irdy_o);
  // R6
  term_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && term_req_i && !(last_o && trdy_i)) |=> last_o);
endmodule

// File: tb/bm_burst_ctrl_tb.sv
module bm_burst_ctrl_tb;
  logic clk = 0;
  logic rst_ni = 0;
  logic sw_rst = 0, we = 0, ce_d = 0, nw_d = 0, mreq = 0, hact = 0;
  logic start = 0, treq = 0, nok = 0, trdy = 0;
  logic [1:0] bm = 2'b01;
  logic [5:0] len = 0;
  logic irdy, last, busy, ce, nw;
  int n_chk = 0, n_bad = 0, cycles = 0;

  // model state
  logic m_busy, m_term, m_end, m_ce, m_nw;
  int   m_cnt;

  always #4 clk = ~clk;

  bm_burst_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sw_rst_i(sw_rst), .bus_mode_i(bm),
    .cfg_we_i(we), .cfg_cnt_en_i(ce_d), .cfg_nowait_i(nw_d), .burst_len_i(len),
    .master_req_i(mreq), .host_act_i(hact), .start_i(start), .term_req_i(treq),
    .next_ok_i(nok), .trdy_i(trdy), .irdy_o(irdy), .last_o(last), .busy_o(busy),
    .cnt_en_o(ce), .nowait_o(nw)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic bit m_fin();
    bit pci = (bm == 2'b01);
    return m_busy && (m_end || m_term || (m_ce && pci && m_cnt == 1) ||
                      (m_nw && pci && !nok));
  endfunction

  // one clock: check outputs mid-cycle, then advance model at the edge
  task automatic cyc();
    bit f, ei, done, pci;
    @(negedge clk);
    pci = (bm == 2'b01);
    f  = m_fin();
    ei = m_busy && (nok || f);
    chk(irdy == ei, "R7/R9/R11 irdy", irdy, ei);
    chk(last == f, "R4/R6/R8 last", last, f);
    chk(busy == m_busy, "R10 busy", busy, m_busy);
    chk(ce == m_ce, "R1/R3 cnt_en", ce, m_ce);
    chk(nw == m_nw, "R2/R3 nowait", nw, m_nw);
    @(posedge clk);
    if (!rst_ni) begin
      m_busy = 0; m_term = 0; m_end = 0; m_ce = 0; m_nw = 0; m_cnt = 1;
    end else begin
      done = ei && trdy;
      if (!m_busy) begin
        m_term = 0; m_end = 0;
        if (start) begin m_busy = 1; m_cnt = (len == 0) ? 1 : len; end
      end else if (done && f) begin
        m_busy = 0; m_term = 0; m_end = 0;
      end else begin
        if (treq) m_term = 1;
        if (f) m_end = 1;
        if (done && m_ce && pci) m_cnt--;
      end
      if (sw_rst) begin m_ce = 0; m_nw = 0; end
      else if (we) begin
        if (mreq || !hact) m_ce = ce_d;
        if (!hact) m_nw = nw_d;
      end
    end
    #1;
  endtask

  task automatic idle_in();
    sw_rst = 0; we = 0; start = 0; treq = 0; nok = 1; trdy = 1;
  endtask

  task automatic cfg_wr(input bit c, input bit n, input bit mr, input bit ha);
    idle_in(); we = 1; ce_d = c; nw_d = n; mreq = mr; hact = ha;
    cyc(); we = 0;
  endtask

  // run a burst with full readiness and count completed phases
  task automatic burst(input int l, input int cap, output int phases);
    idle_in(); len = 6'(l); start = 1; cyc(); start = 0;
    phases = 0;
    while (busy && phases < cap) begin
      if (irdy && trdy) phases++;
      cyc();
    end
  endtask

  initial begin
    int ph;
    void'($urandom(32'd2024));
    m_busy = 0; m_term = 0; m_end = 0; m_ce = 0; m_nw = 0; m_cnt = 1;
    #1;
    cyc(); cyc();
    // reset state
    chk(!irdy && !last && !busy && !ce && !nw, "R3 reset", {irdy, last, busy, ce, nw}, 0);
    rst_ni = 1;
    idle_in(); cyc();

    // R1 / R2 guard windows
    cfg_wr(1, 1, 0, 1);
    chk(ce == 0 && nw == 0, "R1 R2 blocked write", {ce, nw}, 0);
    cfg_wr(1, 1, 1, 1);
    chk(ce == 1 && nw == 0, "R1 R2 master_req window", {ce, nw}, 2);
    cfg_wr(1, 1, 0, 0);
    chk(ce == 1 && nw == 1, "R2 host idle write", {ce, nw}, 3);
    // R3 sw reset beats write
    idle_in(); sw_rst = 1; we = 1; ce_d = 1; nw_d = 1; hact = 0; cyc();
    chk(ce == 0 && nw == 0, "R3 sw reset", {ce, nw}, 0);

    // R4 counted bursts
    cfg_wr(1, 0, 0, 0);
    burst(3, 200, ph);  chk(ph == 3, "R4 len3", ph, 3);
    burst(0, 200, ph);  chk(ph == 1, "R4 len0", ph, 1);
    burst(63, 200, ph); chk(ph == 63, "R4 len63", ph, 63);

    // R5 unlimited, then R6 terminate
    cfg_wr(0, 0, 0, 0);
    burst(2, 70, ph); chk(ph == 70 && busy, "R5 unlimited", ph, 70);
    treq = 1; cyc(); treq = 0; trdy = 0; cyc(); cyc();
    chk(last && irdy && busy, "R6 term holds", {last, irdy, busy}, 7);
    trdy = 1; cyc();
    chk(!busy, "R6 term end", busy, 0);
    // R6 idle request ignored
    idle_in(); treq = 1; cyc(); treq = 0;
    burst(4, 200, ph); chk(ph == 70 || busy, "R6 no stale", ph, 70);
    treq = 1; cyc(); treq = 0; cyc(); cyc();

    // R7 wait states, R8 early end
    idle_in(); start = 1; cyc(); start = 0; nok = 0; cyc();
    chk(!irdy && busy, "R7 wait", irdy, 0);
    cfg_wr(0, 1, 0, 0); nok = 0; trdy = 0;
    cyc(); chk(irdy && last, "R8 early", {irdy, last}, 3);
    nok = 1; cyc(); chk(last, "R10 sticky", last, 1);
    trdy = 1; cyc(); chk(!busy, "R10 idle after", busy, 0);
    // R11 non-PCI: both bits ignored
    cfg_wr(1, 1, 0, 0); bm = 2'b10;
    idle_in(); len = 1; start = 1; cyc(); start = 0; nok = 0; cyc();
    chk(!irdy && !last && busy, "R11 wait in non-pci", {irdy, last}, 0);
    nok = 1; cyc(); cyc(); chk(busy, "R11 unlimited", busy, 1);
    treq = 1; cyc(); treq = 0; cyc(); cyc();
    bm = 2'b01;

    // random
    for (int i = 0; i < 20000; i++) begin
      sw_rst = ($urandom % 64) == 0;
      we     = ($urandom % 12) == 0;
      ce_d   = $urandom; nw_d = $urandom;
      mreq   = $urandom; hact = $urandom;
      start  = ($urandom % 4) == 0;
      treq   = ($urandom % 40) == 0;
      nok    = ($urandom % 3) != 0;
      trdy   = ($urandom % 4) != 0;
      bm     = (($urandom % 8) == 0) ? 2'($urandom) : 2'b01;
      len    = (($urandom % 16) == 0) ? 6'($urandom) : 6'($urandom % 6);
      cyc();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule